// File: doc/BRIEF.md
# PCI Master Termination Classifier

This block sits beside the master-side bus sequencer of a host-to-PCI bridge. From the moment the sequencer raises the start strobe, the block samples the target's DEVSEL#, TRDY# and STOP# lines on every clock. It sorts the end of the transaction into one of four outcomes:

- normal completion
- target disconnect or retry
- target abort
- master abort, when no target claims the cycle

For each outcome it returns a one-clock completion response to the host-side requester, together with any read data.

Three status flags are sticky and are cleared by writing ones to them:

- received target abort
- received master abort
- detected data parity error

Disconnects and retries never touch these flags. After either of them, the block holds off a new bus request for a fixed gap, so that the requester can resume or repeat the transfer. The block checks even parity on read data. On writes it watches the target's parity-error line.

Top module: `pciMstTerm`

## Requirements
- R1: rspValid pulses for exactly one clock per finished transaction, and rspCode carries the outcome: 2'b00 means normal, 2'b01 means hard-fail and 2'b10 means resume-pending. A data phase with devselN=0, trdyN=0, stopN=1 while lastPhase=1 ends the transaction with code 2'b00.
- R2: A clock with stopN=0 and devselN=0 is a disconnect and ends the transaction with code 2'b10. If trdyN=0 in that same clock on a read, that word is transferred and returned on rspData.
- R3: A retry (stopN=0, devselN=0, trdyN=1) ends the transaction with code 2'b10 and transfers no data.
- R4: A clock with stopN=0 and devselN=1 is a target abort. It returns code 2'b01 and sets stsRta.
- R5: If devselN has not been sampled low on any of the first 5 clocks after the start clock, the transaction ends as a master abort on that 5th clock. It returns code 2'b00 and sets stsRma. A devselN low on the 5th clock is not a master abort.
- R6: rspData returns the last transferred word on a read and all ones on a master-aborted read. It returns zero on any write.
- R7: reqHold is high for exactly 2 clocks after a disconnect or retry response. A txnStart raised while reqHold is high is ignored.
- R8: On a read data transfer (devselN=0, trdyN=0), the XOR of adIn and parIn must be 0. Otherwise stsDpe is set. On a write, perrN=0 on any active clock sets stsDpe.
- R9: The status flags {stsDpe, stsRma, stsRta} map to stsClear bits [2], [1] and [0]. They stay set until a clock with the matching stsClear bit high clears them. A set in the same clock wins over the clear.
- R10: Disconnects and retries leave all three status flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| txnStart | input | 1 | Address phase begins this clock |
| txnWrite | input | 1 | Transaction is a write; held for its duration |
| lastPhase | input | 1 | Current data phase is the master's final one |
| devselN | input | 1 | Target claim, active low |
| trdyN | input | 1 | Target ready, active low |
| stopN | input | 1 | Target stop request, active low |
| perrN | input | 1 | Target-reported write parity error, active low |
| adIn | input | 32 | Read data from the bus |
| parIn | input | 1 | Even parity bit for adIn |
| stsClear | input | 3 | Write-one-to-clear strobes for the status flags |
| rspValid | output | 1 | Completion response strobe |
| rspCode | output | 2 | Completion outcome code |
| rspData | output | 32 | Read data or fill value returned with the response |
| reqHold | output | 1 | Bus request must stay low |
| stsRta | output | 1 | Sticky received-target-abort flag |
| stsRma | output | 1 | Sticky received-master-abort flag |
| stsDpe | output | 1 | Sticky detected-parity-error flag |

## Verification
A corrupted decode-window count shows at the ports as a master-abort response that comes one or more clocks too early or too late. A wrongly remembered DEVSEL# claim turns a slow but claimed cycle into a spurious master abort on its fifth clock. A stuck phase state either suppresses rspValid or repeats it, and a wrong hold count stretches or shortens reqHold. The reference model compares every output on every clock, so each of these faults is visible at the first clock edge where it diverges.

// File: rtl/pciMstTermPkg.sv
`timescale 1ns/1ps
package pciMstTermPkg;
  typedef enum logic [1:0] {
    RSP_OK     = 2'b00,
    RSP_FAIL   = 2'b01,
    RSP_RESUME = 2'b10
  } rspCode_e;

  typedef struct packed {
    logic     done;
    rspCode_e code;
    logic     loadData;
    logic     allOnes;
    logic     setRta;
    logic     setRma;
    logic     setDpe;
  } ctlStrobe_t;
endpackage

// File: rtl/pciMstTermCtl.sv
`timescale 1ns/1ps
module pciMstTermCtl
  import pciMstTermPkg::*;
#(
  parameter int DECODE_WIN = 5,
  parameter int GAP        = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       txnStart,
  input  logic       txnWrite,
  input  logic       lastPhase,
  input  logic       devselN,
  input  logic       trdyN,
  input  logic       stopN,
  input  logic       perrN,
  input  logic       parFail,
  output ctlStrobe_t strb,
  output logic       reqHold
);
  localparam int CW = (DECODE_WIN > 1) ? $clog2(DECODE_WIN) : 1;
  localparam int HW = (GAP > 1) ? $clog2(GAP) : 1;
  localparam logic [CW-1:0] WIN_LAST = CW'(DECODE_WIN - 1);
  localparam logic [HW-1:0] HOLD_LOAD = HW'(GAP - 1);

  typedef enum logic [1:0] {S_IDLE, S_ACTIVE, S_HOLD} state_e;

  state_e        state, nState;
  logic [CW-1:0] winCnt;
  logic [HW-1:0] holdCnt;
  logic          devselSeen;
  logic          xfer;

  assign xfer = !devselN && !trdyN;

  always_comb begin
    strb   = '0;
    nState = state;
    case (state)
      S_IDLE: if (txnStart) nState = S_ACTIVE;
      S_ACTIVE: begin
        if (txnWrite && !perrN)             strb.setDpe = 1'b1;
        if (!txnWrite && xfer && parFail)   strb.setDpe = 1'b1;
        if (!stopN && devselN) begin
          strb.done   = 1'b1;
          strb.code   = RSP_FAIL;
          strb.setRta = 1'b1;
          nState      = S_IDLE;
        end else if (!stopN) begin
          strb.done     = 1'b1;
          strb.code     = RSP_RESUME;
          strb.loadData = xfer && !txnWrite;
          nState        = S_HOLD;
        end else if (xfer && lastPhase) begin
          strb.done     = 1'b1;
          strb.code     = RSP_OK;
          strb.loadData = !txnWrite;
          nState        = S_IDLE;
        end else if (devselN && !devselSeen && winCnt == WIN_LAST) begin
          strb.done    = 1'b1;
          strb.code    = RSP_OK;
          strb.allOnes = !txnWrite;
          strb.setRma  = 1'b1;
          nState       = S_IDLE;
        end
      end
      S_HOLD: if (holdCnt == '0) nState = S_IDLE;
      default: nState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= S_IDLE;
      winCnt     <= '0;
      holdCnt    <= '0;
      devselSeen <= 1'b0;
    end else begin
      state <= nState;
      if (state == S_IDLE) begin
        winCnt     <= '0;
        devselSeen <= 1'b0;
      end else if (state == S_ACTIVE) begin
        if (winCnt != WIN_LAST) winCnt <= winCnt + 1'b1;
        if (!devselN) devselSeen <= 1'b1;
      end
      if (nState == S_HOLD && state != S_HOLD) holdCnt <= HOLD_LOAD;
      else if (state == S_HOLD && holdCnt != '0) holdCnt <= holdCnt - 1'b1;
    end
  end

  assign reqHold = (state == S_HOLD);

  // R5: the decode window counter never runs past its final sample
  a_r5_window_bound: assert property (@(posedge clk) disable iff (!rstN)
    state == S_ACTIVE |-> winCnt <= WIN_LAST);

  // R7: a started hold lasts longer than one clock when the gap exceeds one
  if (GAP >= 2) begin : g_holdChk
    a_r7_hold_min: assert property (@(posedge clk) disable iff (!rstN)
      $rose(reqHold) |=> reqHold);
  end

  // R7: a start strobe during the hold does not launch a transaction
  a_r7_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_HOLD && txnStart) |=> state != S_ACTIVE);
endmodule

// File: rtl/pciMstTermDp.sv
`timescale 1ns/1ps
module pciMstTermDp
  import pciMstTermPkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strb,
  input  logic [DATA_W-1:0] adIn,
  input  logic              parIn,
  input  logic [2:0]        stsClear,
  output logic              parFail,
  output logic              rspValid,
  output logic [1:0]        rspCode,
  output logic [DATA_W-1:0] rspData,
  output logic              stsRta,
  output logic              stsRma,
  output logic              stsDpe
);
  logic [2:0] setVec, stsQ;

  assign parFail = ^{adIn, parIn};
  assign setVec  = {strb.setDpe, strb.setRma, strb.setRta};

  for (genvar i = 0; i < 3; i++) begin : g_sts
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          stsQ[i] <= 1'b0;
      else if (setVec[i]) stsQ[i] <= 1'b1;
      else if (stsClear[i]) stsQ[i] <= 1'b0;
    end
  end

  assign {stsDpe, stsRma, stsRta} = stsQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspCode  <= RSP_OK;
      rspData  <= '0;
    end else begin
      rspValid <= strb.done;
      if (strb.done) begin
        rspCode <= strb.code;
        rspData <= strb.allOnes ? '1 : (strb.loadData ? adIn : '0);
      end
    end
  end

  // R1: the response strobe is a single-clock pulse
  a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  // R4: a hard-fail response always comes with the target-abort flag
  a_r4_fail_logged: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspCode == RSP_FAIL) |-> stsRta);

  // R5: a newly set master-abort flag comes with a normal-coded response
  a_r5_rma_response: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stsRma) |-> (rspValid && rspCode == RSP_OK));
endmodule

// File: rtl/pciMstTerm.sv
`timescale 1ns/1ps
module pciMstTerm
  import pciMstTermPkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int DECODE_WIN = 5,
  parameter int GAP        = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txnStart,
  input  logic              txnWrite,
  input  logic              lastPhase,
  input  logic              devselN,
  input  logic              trdyN,
  input  logic              stopN,
  input  logic              perrN,
  input  logic [DATA_W-1:0] adIn,
  input  logic              parIn,
  input  logic [2:0]        stsClear,
  output logic              rspValid,
  output logic [1:0]        rspCode,
  output logic [DATA_W-1:0] rspData,
  output logic              reqHold,
  output logic              stsRta,
  output logic              stsRma,
  output logic              stsDpe
);
  ctlStrobe_t strb;
  logic       parFail;

  pciMstTermCtl #(.DECODE_WIN(DECODE_WIN), .GAP(GAP)) u_ctl (
    .clk(clk), .rstN(rstN), .txnStart(txnStart), .txnWrite(txnWrite),
    .lastPhase(lastPhase), .devselN(devselN), .trdyN(trdyN), .stopN(stopN),
    .perrN(perrN), .parFail(parFail), .strb(strb), .reqHold(reqHold)
  );

  pciMstTermDp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .adIn(adIn), .parIn(parIn),
    .stsClear(stsClear), .parFail(parFail), .rspValid(rspValid),
    .rspCode(rspCode), .rspData(rspData), .stsRta(stsRta), .stsRma(stsRma),
    .stsDpe(stsDpe)
  );

  // R7 and R10: a hold opens only on a resume-pending response
  a_r7_hold_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(reqHold) |-> (rspValid && rspCode == RSP_RESUME));
endmodule

// File: tb/pciMstTerm_tb.sv
`timescale 1ns/1ps
module pciMstTerm_tb;
  localparam int GAP = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        txnStart = 0, txnWrite = 0, lastPhase = 0;
  logic        devselN = 1, trdyN = 1, stopN = 1, perrN = 1;
  logic [31:0] adIn = '0;
  logic        parIn = 0;
  logic [2:0]  stsClear = '0;
  logic        rspValid, reqHold, stsRta, stsRma, stsDpe;
  logic [1:0]  rspCode;
  logic [31:0] rspData;

  int checks = 0, errors = 0;
  bit live = 0;

  always #4 clk = ~clk;

  pciMstTerm u_dut (
    .clk(clk), .rstN(rstN), .txnStart(txnStart), .txnWrite(txnWrite),
    .lastPhase(lastPhase), .devselN(devselN), .trdyN(trdyN), .stopN(stopN),
    .perrN(perrN), .adIn(adIn), .parIn(parIn), .stsClear(stsClear),
    .rspValid(rspValid), .rspCode(rspCode), .rspData(rspData),
    .reqHold(reqHold), .stsRta(stsRta), .stsRma(stsRma), .stsDpe(stsDpe)
  );

  // behavioural reference
  int          mState, mCnt, mHold;
  bit          mSeen, eV, eHold, mXfer;
  bit [1:0]    eC;
  bit [31:0]   eD;
  bit [2:0]    eSts, setv;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always begin
    @(posedge clk);
    if (!rstN) begin
      mState = 0; mCnt = 0; mHold = 0; mSeen = 0;
      eV = 0; eHold = 0; eC = 0; eD = 0; eSts = 0;
    end else begin
      setv = 0; eV = 0;
      mXfer = !devselN && !trdyN;
      case (mState)
        0: if (txnStart) begin mState = 1; mCnt = 0; mSeen = 0; end
        1: begin
          if (txnWrite && !perrN) setv[2] = 1;
          if (!txnWrite && mXfer && (^{adIn, parIn})) setv[2] = 1;
          if (!stopN && devselN) begin
            eV = 1; eC = 2'b01; eD = 0; setv[0] = 1; mState = 0;
          end else if (!stopN) begin
            eV = 1; eC = 2'b10; eD = (mXfer && !txnWrite) ? adIn : 32'h0;
            mState = 2; mHold = GAP;
          end else if (mXfer && lastPhase) begin
            eV = 1; eC = 2'b00; eD = txnWrite ? 32'h0 : adIn; mState = 0;
          end else if (devselN && !mSeen && mCnt == 4) begin
            eV = 1; eC = 2'b00; eD = txnWrite ? 32'h0 : 32'hFFFF_FFFF;
            setv[1] = 1; mState = 0;
          end else mCnt++;
          if (!devselN) mSeen = 1;
        end
        default: begin mHold--; if (mHold == 0) mState = 0; end
      endcase
      eSts = (eSts & ~stsClear) | setv;
      eHold = (mState == 2);
    end
    #1;
    if (live) begin
      chk("R1 rspValid", rspValid, eV);
      if (eV) begin
        chk("R1 rspCode", rspCode, eC);
        chk("R6 rspData", rspData, eD);
      end
      chk("R7 reqHold", reqHold, eHold);
      chk("R4 stsRta", stsRta, eSts[0]);
      chk("R5 stsRma", stsRma, eSts[1]);
      chk("R8 stsDpe", stsDpe, eSts[2]);
    end
  end

  task automatic idle();
    txnStart = 0; devselN = 1; trdyN = 1; stopN = 1; perrN = 1;
    lastPhase = 0; stsClear = 0;
  endtask

  task automatic start(bit wr);
    idle(); txnWrite = wr; txnStart = 1;
    @(negedge clk);
    txnStart = 0;
  endtask

  task automatic phase(bit dv, bit tr, bit st, bit last, logic [31:0] d, bit badPar);
    devselN = dv; trdyN = tr; stopN = st; lastPhase = last; adIn = d;
    parIn = badPar ? ~(^d) : (^d);
    @(negedge clk);
    idle();
  endtask

  task automatic expectRsp(string tag, logic [1:0] c, logic [31:0] d);
    chk({tag, " valid"}, rspValid, 1'b1);
    chk({tag, " code"}, rspCode, c);
    chk({tag, " data"}, rspData, d);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rstN = 1; live = 1;
    // reset state
    chk("R1 reset valid", rspValid, 0);
    chk("R9 reset flags", {stsDpe, stsRma, stsRta}, 3'b000);
    chk("R7 reset hold", reqHold, 0);

    // R1 R6: normal read, wait state then two data phases
    start(0);
    phase(0, 1, 1, 0, 32'h0, 0);
    phase(0, 0, 1, 0, 32'h1111_2222, 0);
    phase(0, 0, 1, 1, 32'hA5A5_0F0F, 0);
    expectRsp("R1 normal read", 2'b00, 32'hA5A5_0F0F);
    @(negedge clk);
    chk("R1 pulse one clock", rspValid, 0);

    // R6: normal write returns zero
    start(1);
    phase(0, 0, 1, 0, 32'h3, 0);
    phase(0, 0, 1, 1, 32'h4, 0);
    expectRsp("R6 normal write", 2'b00, 32'h0);

    // R2: disconnect with data on read
    start(0);
    phase(0, 0, 1, 0, 32'h5, 0);
    phase(0, 0, 0, 0, 32'hDEAD_BEEF, 0);
    expectRsp("R2 disconnect data", 2'b10, 32'hDEAD_BEEF);
    chk("R10 disconnect flags", {stsDpe, stsRma, stsRta}, 3'b000);
    chk("R7 hold clock 1", reqHold, 1);
    @(negedge clk);
    chk("R7 hold clock 2", reqHold, 1);
    @(negedge clk);
    chk("R7 hold released", reqHold, 0);

    // R3: retry on first phase; a start during the hold is ignored
    start(0);
    phase(0, 1, 0, 0, 32'h77, 0);
    expectRsp("R3 retry", 2'b10, 32'h0);
    chk("R10 retry flags", {stsDpe, stsRma, stsRta}, 3'b000);
    start(0);
    repeat (7) begin
      chk("R7 ignored start no response", rspValid, 0);
      @(negedge clk);
    end
    chk("R7 ignored start no abort", stsRma, 0);

    // R4: target abort
    start(1);
    phase(0, 1, 1, 0, 32'h0, 0);
    phase(1, 1, 0, 0, 32'h0, 0);
    expectRsp("R4 target abort", 2'b01, 32'h0);
    chk("R4 flag set", stsRta, 1);

    // R5 R6: master abort read
    start(0);
    repeat (4) phase(1, 1, 1, 0, 32'h0, 0);
    chk("R5 not yet aborted", rspValid, 0);
    phase(1, 1, 1, 0, 32'h0, 0);
    expectRsp("R5 master abort read", 2'b00, 32'hFFFF_FFFF);
    chk("R5 flag set", stsRma, 1);

    // R9: clear both flags, confirm sticky before
    chk("R9 sticky", {stsRma, stsRta}, 2'b11);
    stsClear = 3'b011;
    @(negedge clk);
    stsClear = 0;
    chk("R9 cleared", {stsDpe, stsRma, stsRta}, 3'b000);

    // R5: claim on 5th clock is not a master abort
    start(0);
    repeat (4) phase(1, 1, 1, 0, 32'h0, 0);
    phase(0, 0, 1, 1, 32'h0BAD_F00D, 0);
    expectRsp("R5 late claim", 2'b00, 32'h0BAD_F00D);
    chk("R5 late claim no flag", stsRma, 0);

    // R6: master abort write returns zero
    start(1);
    repeat (5) phase(1, 1, 1, 0, 32'h0, 0);
    expectRsp("R6 master abort write", 2'b00, 32'h0);

    // R8: bad read parity
    start(0);
    phase(0, 0, 1, 1, 32'h0000_0007, 1);
    chk("R8 read parity", stsDpe, 1);
    stsClear = 3'b100;
    @(negedge clk);
    stsClear = 0;
    chk("R9 dpe cleared", stsDpe, 0);

    // R8: target parity error on write
    start(1);
    perrN = 0;
    phase(0, 0, 1, 1, 32'h9, 0);
    chk("R8 write perr", stsDpe, 1);

    // R9: set wins over clear in the same clock
    stsClear = 3'b111;
    start(1);
    stsClear = 3'b111;
    phase(1, 1, 0, 0, 32'h0, 0);
    chk("R9 set wins", stsRta, 1);

    repeat (4) @(negedge clk);
    live = 0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule